// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces the Repeated Start condition of an I2C master on open-drain SCL and SDA lines. The host programs a 7-bit reload value and sets a request bit. While the master has no other bus event in progress, the block then works through a fixed series of phases. It pulls SCL low and releases SDA. It releases SCL once SDA reads back high. It holds both lines high for one period. Finally it pulls SDA low while SCL stays high. A reloadable down-counter times every phase, and each phase waits on the level it reads back from the bus before the counter is loaded or the next phase begins.

Both bus inputs pass through a two-stage synchronizer. A separate detector sets a sticky status bit whenever it sees SDA fall while SCL is high. Once the last phase ends, the block raises an interrupt flag and signals that the transmit buffer may be written. While the sequence runs, command writes are ignored and transmit-buffer writes are refused and flagged. If the bus reads back a conflict, the block abandons the sequence, releases both lines and keeps a sticky collision flag.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A write of 1 to bit 1 of the command register (address 0) starts a sequence only if the block is idle and `evt_busy_i` is low. Otherwise the write has no effect: `req_o` and `busy_o` stay low and SCL is not driven.
- R2: Once a request is accepted, `req_o` and `busy_o` go high and SCL is driven low at once. The phase counter is loaded with the reload value only after SCL is read back low, and every timed phase lasts reload+1 clocks.
- R3: While SCL is held low, SDA is released for reload+1 clocks. SCL is released only after that period has expired and SDA reads back high. If SDA is held low, SCL stays driven low for as long as SDA is low.
- R4: After SCL reads back high, both lines stay released for reload+1 clocks.
- R5: SDA is then driven low for reload+1 clocks with SCL released. At the end, `req_o` clears, `irq_o` sets, and SDA stays driven low after the sequence.
- R6: `start_det_o` sets when the synchronized SDA falls while the synchronized SCL is high, and it stays set until cleared.
- R7: A write to the transmit buffer (address 2) while `busy_o` is high sets `wcol_o` and leaves `txbuf_o` unchanged. The same write while idle stores the data.
- R8: Command-register writes made while `busy_o` is high are ignored: a write of 0 does not clear `req_o`, and the sequence still completes.
- R9: A bus collision is detected in two cases. The first is SDA reading low at the moment SCL reads back high after being released. The second is SCL reading low during the both-high phase. On a collision the sequence aborts, both lines are released, `req_o` clears and `bcol_o` sets and stays set.
- R10: Writing to address 3 clears flags, one bit per flag, and leaves the rest alone: bit 0 clears `irq_o`, bit 1 clears `wcol_o`, bit 2 clears `bcol_o` and bit 3 clears `start_det_o`.
- R11: A write to address 1 sets the reload value from data bits 6:0.
- R12: `buf_wr_ok_o` is high exactly when the block is idle and `irq_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_busy_i | input | 1 | Another master bus event is in progress |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| scl_i | input | 1 | SCL line level read from the pad |
| sda_i | input | 1 | SDA line level read from the pad |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |
| req_o | output | 1 | Request bit read-back |
| busy_o | output | 1 | Sequence in progress |
| start_det_o | output | 1 | Start condition seen on the bus (sticky) |
| irq_o | output | 1 | Sequence complete interrupt flag |
| wcol_o | output | 1 | Transmit-buffer write collision flag |
| bcol_o | output | 1 | Bus collision flag |
| txbuf_o | output | 8 | Transmit buffer contents |
| buf_wr_ok_o | output | 1 | Transmit buffer may be written |

## Verification
The bench measures each phase length in clocks for two reload values, and for both possible levels of SDA at the start of the sequence. A design that loads the counter before SCL reads back low, or that counts reload clocks instead of reload+1, gives phase lengths that are off by the synchronizer delay or by one. SDA is held low by an external driver during the first phase to confirm that SCL is never released early. Both collision cases are forced at the pins, and a design that keeps driving a line or leaves the request set is caught. A design that lets a mid-sequence command write or buffer write through shows up as a cleared request or a changed buffer.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
   typedef enum logic [2:0] {
      RS_IDLE,
      RS_PULL_SCL,
      RS_SDA_REL,
      RS_SCL_REL,
      RS_BOTH_HI,
      RS_SDA_LO
   } rs_state_e;

   localparam logic [1:0] ADDR_CMD    = 2'd0;
   localparam logic [1:0] ADDR_RELOAD = 2'd1;
   localparam logic [1:0] ADDR_TXBUF  = 2'd2;
   localparam logic [1:0] ADDR_CLR    = 2'd3;

   localparam int CLR_IRQ  = 0;
   localparam int CLR_WCOL = 1;
   localparam int CLR_BCOL = 2;
   localparam int CLR_SDET = 3;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= {STAGES{RST_VAL}};
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];
endmodule

// File: rtl/i2c_rs_brg.sv
module i2c_rs_brg #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         run,
   input  logic [W-1:0] reload,
   output logic         zero
);
   if (W < 1) begin : g_bad_w
      $error("i2c_rs_brg: W must be positive");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= reload;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_rs_startdet.sv
module i2c_rs_startdet (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_pulse
);
   logic scl_prev, sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign start_pulse = scl_s & scl_prev & sda_prev & ~sda_s;
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq
   import i2c_rs_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int RELOAD_W      = 7,
   parameter int SYNC_STAGES   = 2,
   parameter int CMD_LOCK_BITS = 5,
   parameter int REQ_BIT       = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_busy_i,
   input  logic              host_we,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   output logic              req_o,
   output logic              busy_o,
   output logic              start_det_o,
   output logic              irq_o,
   output logic              wcol_o,
   output logic              bcol_o,
   output logic [DATA_W-1:0] txbuf_o,
   output logic              buf_wr_ok_o
);
   localparam int N_LINES  = 2;
   localparam int LINE_SCL = 0;
   localparam int LINE_SDA = 1;

   if (RELOAD_W > DATA_W) begin : g_bad_reload
      $error("i2c_rstart_seq: RELOAD_W exceeds DATA_W");
   end
   if (REQ_BIT >= CMD_LOCK_BITS || CMD_LOCK_BITS > DATA_W) begin : g_bad_cmd
      $error("i2c_rstart_seq: request bit must lie in the locked command field");
   end
   if (DATA_W <= CLR_SDET) begin : g_bad_data
      $error("i2c_rstart_seq: DATA_W too small for clear register");
   end

   // Input synchronizers, one per bus line
   logic [N_LINES-1:0] line_raw, line_s;
   assign line_raw[LINE_SCL] = scl_i;
   assign line_raw[LINE_SDA] = sda_i;

   for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      i2c_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (line_raw[g]),
         .q    (line_s[g])
      );
   end

   logic scl_s, sda_s;
   assign scl_s = line_s[LINE_SCL];
   assign sda_s = line_s[LINE_SDA];

   // Host decode
   logic cmd_wr, rld_wr, txb_wr, clr_wr;
   assign cmd_wr = host_we && host_addr == ADDR_CMD;
   assign rld_wr = host_we && host_addr == ADDR_RELOAD;
   assign txb_wr = host_we && host_addr == ADDR_TXBUF;
   assign clr_wr = host_we && host_addr == ADDR_CLR;

   rs_state_e          state, nxt;
   logic               req_q, sda_hold, irq_q, wcol_q, bcol_q, sdet_q;
   logic [RELOAD_W-1:0] reload_q;
   logic [DATA_W-1:0]  txbuf_q;
   logic               accept, brg_load, brg_run, brg_zero, done, coll, start_pulse;

   assign accept = cmd_wr && host_wdata[REQ_BIT] && state == RS_IDLE && !evt_busy_i;

   i2c_rs_brg #(.W(RELOAD_W)) brg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (brg_load),
      .run   (brg_run),
      .reload(reload_q),
      .zero  (brg_zero)
   );

   i2c_rs_startdet sdet_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .start_pulse(start_pulse)
   );

   assign brg_run = state == RS_SDA_REL || state == RS_BOTH_HI || state == RS_SDA_LO;

   always_comb begin
      nxt      = state;
      brg_load = 1'b0;
      done     = 1'b0;
      coll     = 1'b0;
      case (state)
         RS_IDLE:     if (accept) nxt = RS_PULL_SCL;
         RS_PULL_SCL: if (!scl_s) begin
                         brg_load = 1'b1;
                         nxt      = RS_SDA_REL;
                      end
         RS_SDA_REL:  if (brg_zero && sda_s) nxt = RS_SCL_REL;
         RS_SCL_REL:  if (scl_s) begin
                         if (!sda_s) coll = 1'b1;
                         else begin
                            brg_load = 1'b1;
                            nxt      = RS_BOTH_HI;
                         end
                      end
         RS_BOTH_HI:  if (!scl_s) coll = 1'b1;
                      else if (brg_zero) begin
                         brg_load = 1'b1;
                         nxt      = RS_SDA_LO;
                      end
         RS_SDA_LO:   if (brg_zero) begin
                         done = 1'b1;
                         nxt  = RS_IDLE;
                      end
         default:     nxt = RS_IDLE;
      endcase
      if (coll) nxt = RS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RS_IDLE;
         req_q    <= 1'b0;
         sda_hold <= 1'b0;
      end else begin
         state <= nxt;
         if (accept)          req_q <= 1'b1;
         else if (done || coll) req_q <= 1'b0;
         if (done)            sda_hold <= 1'b1;
         else if (coll)       sda_hold <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q    <= 1'b0;
         wcol_q   <= 1'b0;
         bcol_q   <= 1'b0;
         sdet_q   <= 1'b0;
         reload_q <= '0;
         txbuf_q  <= '0;
      end else begin
         if (done)                                irq_q <= 1'b1;
         else if (clr_wr && host_wdata[CLR_IRQ])  irq_q <= 1'b0;
         if (txb_wr && state != RS_IDLE)          wcol_q <= 1'b1;
         else if (clr_wr && host_wdata[CLR_WCOL]) wcol_q <= 1'b0;
         if (coll)                                bcol_q <= 1'b1;
         else if (clr_wr && host_wdata[CLR_BCOL]) bcol_q <= 1'b0;
         if (start_pulse)                         sdet_q <= 1'b1;
         else if (clr_wr && host_wdata[CLR_SDET]) sdet_q <= 1'b0;
         if (rld_wr) reload_q <= host_wdata[RELOAD_W-1:0];
         if (txb_wr && state == RS_IDLE) txbuf_q <= host_wdata;
      end
   end

   always_comb begin
      case (state)
         RS_PULL_SCL: begin scl_oe_o = 1'b1; sda_oe_o = sda_hold; end
         RS_SDA_REL:  begin scl_oe_o = 1'b1; sda_oe_o = 1'b0;     end
         RS_SCL_REL,
         RS_BOTH_HI:  begin scl_oe_o = 1'b0; sda_oe_o = 1'b0;     end
         RS_SDA_LO:   begin scl_oe_o = 1'b0; sda_oe_o = 1'b1;     end
         default:     begin scl_oe_o = 1'b0; sda_oe_o = sda_hold; end
      endcase
   end

   assign req_o       = req_q;
   assign busy_o      = state != RS_IDLE;
   assign start_det_o = sdet_q;
   assign irq_o       = irq_q;
   assign wcol_o      = wcol_q;
   assign bcol_o      = bcol_q;
   assign txbuf_o     = txbuf_q;
   assign buf_wr_ok_o = state == RS_IDLE && irq_q;
endmodule

// File: rtl/i2c_rstart_seq_chk.sv
module i2c_rstart_seq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_busy_i,
   input logic              host_we,
   input logic [1:0]        host_addr,
   input logic              scl_oe_o,
   input logic              sda_oe_o,
   input logic              req_o,
   input logic              busy_o,
   input logic              irq_o,
   input logic              wcol_o,
   input logic              bcol_o,
   input logic [DATA_W-1:0] txbuf_o
);
   // R1
   idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && evt_busy_i) |=> !busy_o);

   // R2
   accept_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (scl_oe_o && req_o));

   // R5
   finish_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (sda_oe_o && !scl_oe_o && !req_o && !busy_o));

   // R7
   buf_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && host_we && host_addr == 2'd2) |=> ($stable(txbuf_o) && wcol_o));

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |-> !busy_o);

   // R9
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bcol_o) |-> (!scl_oe_o && !sda_oe_o && !req_o && !busy_o));
endmodule

bind i2c_rstart_seq i2c_rstart_seq_chk #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_busy_i(evt_busy_i),
   .host_we   (host_we),
   .host_addr (host_addr),
   .scl_oe_o  (scl_oe_o),
   .sda_oe_o  (sda_oe_o),
   .req_o     (req_o),
   .busy_o    (busy_o),
   .irq_o     (irq_o),
   .wcol_o    (wcol_o),
   .bcol_o    (bcol_o),
   .txbuf_o   (txbuf_o)
);

// File: tb/i2c_rstart_seq_tb_top.sv
module i2c_rstart_seq_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_busy_i = 1'b0;
   logic       host_we = 1'b0;
   logic [1:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       scl_force = 1'b0, sda_force = 1'b0;
   logic       scl_oe_o, sda_oe_o, req_o, busy_o, start_det_o, irq_o, wcol_o, bcol_o, buf_wr_ok_o;
   logic [7:0] txbuf_o;
   logic       scl_i, sda_i;

   int checks = 0;
   int errors = 0;

   assign scl_i = !(scl_oe_o || scl_force);
   assign sda_i = !(sda_oe_o || sda_force);

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_rstart_seq dut_i (
      .clk(clk), .rst_n(rst_n), .evt_busy_i(evt_busy_i),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .scl_i(scl_i), .sda_i(sda_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
      .req_o(req_o), .busy_o(busy_o), .start_det_o(start_det_o), .irq_o(irq_o),
      .wcol_o(wcol_o), .bcol_o(bcol_o), .txbuf_o(txbuf_o), .buf_wr_ok_o(buf_wr_ok_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Runs a full sequence and checks every phase length (R2 R3 R4 R5 R6 R11 R12)
   task automatic test_sequence(input int rld, input bit held_low);
      int n_pull_hi, n_sdarel, n_both, n_sdalo, n;
      host_write(2'd1, 8'(rld));
      host_write(2'd3, 8'h0F);
      chk("R10 start_det cleared", start_det_o, 0);
      host_write(2'd0, 8'h02);
      chk("R2 req set", req_o, 1);
      chk("R2 scl pulled", scl_oe_o, 1);
      n_pull_hi = 0; n_sdarel = 0; n_both = 0; n_sdalo = 0; n = 0;
      while (!irq_o && n < 2000) begin
         if (scl_oe_o && sda_oe_o) n_pull_hi++;
         else if (scl_oe_o && !sda_oe_o) n_sdarel++;
         else if (!scl_oe_o && !sda_oe_o) n_both++;
         else n_sdalo++;
         if (busy_o) chk("R12 no buffer ok while busy", buf_wr_ok_o, 0);
         n++;
         @(negedge clk);
      end
      chk("R5 irq set", irq_o, 1);
      if (held_low) begin
         chk("R2 pull phase with sda low", n_pull_hi, 3);
         chk("R3 sda released phase", n_sdarel, rld + 1);
      end else begin
         chk("R3 sda released phase incl pull", n_sdarel, rld + 4);
      end
      chk("R4 both released phase", n_both, rld + 4);
      chk("R5 sda low phase", n_sdalo, rld + 1);
      chk("R5 req cleared", req_o, 0);
      chk("R5 sda held low", sda_oe_o, 1);
      chk("R5 scl released", scl_oe_o, 0);
      chk("R6 start detected", start_det_o, 1);
      chk("R12 buffer ok", buf_wr_ok_o, 1);
   endtask

   task automatic test_reset;
      chk("R1 reset busy", busy_o, 0);
      chk("R1 reset req", req_o, 0);
      chk("R2 reset scl", scl_oe_o, 0);
      chk("R5 reset sda", sda_oe_o, 0);
      chk("R5 reset irq", irq_o, 0);
      chk("R9 reset bcol", bcol_o, 0);
      chk("R7 reset wcol", wcol_o, 0);
      chk("R6 reset start", start_det_o, 0);
   endtask

   task automatic test_busy_reject;
      evt_busy_i = 1'b1;
      host_write(2'd0, 8'h02);
      wait_cycles(5);
      chk("R1 rejected busy", busy_o, 0);
      chk("R1 rejected req", req_o, 0);
      chk("R1 rejected scl", scl_oe_o, 0);
      evt_busy_i = 1'b0;
   endtask

   task automatic test_locks;
      host_write(2'd3, 8'h0F);
      host_write(2'd2, 8'hA5);
      chk("R7 idle write stored", txbuf_o, 8'hA5);
      chk("R7 no wcol idle", wcol_o, 0);
      host_write(2'd1, 8'd6);
      host_write(2'd0, 8'h02);
      wait_cycles(2);
      host_write(2'd2, 8'h3C);
      chk("R7 wcol set", wcol_o, 1);
      chk("R7 buffer unchanged", txbuf_o, 8'hA5);
      host_write(2'd0, 8'h00);
      chk("R8 req kept", req_o, 1);
      chk("R8 still busy", busy_o, 1);
      for (int i = 0; i < 200 && !irq_o; i++) @(negedge clk);
      chk("R8 sequence completes", irq_o, 1);
      chk("R8 req cleared at end", req_o, 0);
   endtask

   task automatic test_gate;
      host_write(2'd1, 8'd2);
      host_write(2'd3, 8'h0F);
      host_write(2'd0, 8'h02);
      sda_force = 1'b1;
      wait_cycles(20);
      chk("R3 scl held while sda low", scl_oe_o, 1);
      chk("R3 still busy", busy_o, 1);
      sda_force = 1'b0;
      for (int i = 0; i < 200 && !irq_o; i++) @(negedge clk);
      chk("R3 completes after sda free", irq_o, 1);
   endtask

   task automatic test_coll_sda;
      host_write(2'd1, 8'd8);
      host_write(2'd3, 8'h0F);
      host_write(2'd0, 8'h02);
      for (int i = 0; i < 200 && scl_oe_o; i++) @(negedge clk);
      sda_force = 1'b1;
      wait_cycles(4);
      chk("R9 sda low collision flag", bcol_o, 1);
      chk("R9 scl released", scl_oe_o, 0);
      chk("R9 sda released", sda_oe_o, 0);
      chk("R9 req cleared", req_o, 0);
      chk("R9 no irq", irq_o, 0);
      sda_force = 1'b0;
      wait_cycles(4);
      chk("R9 bcol sticky", bcol_o, 1);
   endtask

   task automatic test_coll_scl;
      host_write(2'd3, 8'h0F);
      host_write(2'd1, 8'd10);
      host_write(2'd0, 8'h02);
      for (int i = 0; i < 200 && scl_oe_o; i++) @(negedge clk);
      wait_cycles(4);
      chk("R9 in high phase", busy_o, 1);
      scl_force = 1'b1;
      wait_cycles(4);
      chk("R9 scl low collision flag", bcol_o, 1);
      chk("R9 busy cleared", busy_o, 0);
      chk("R9 lines released", {scl_oe_o, sda_oe_o}, 0);
      scl_force = 1'b0;
      wait_cycles(4);
   endtask

   task automatic test_clear;
      host_write(2'd1, 8'd4);
      host_write(2'd0, 8'h02);
      wait_cycles(2);
      host_write(2'd2, 8'h11);
      for (int i = 0; i < 200 && !irq_o; i++) @(negedge clk);
      chk("R10 flags before clear", {irq_o, wcol_o, bcol_o, start_det_o}, 4'b1111);
      host_write(2'd3, 8'h02);
      chk("R10 only wcol cleared", {irq_o, wcol_o, bcol_o, start_det_o}, 4'b1011);
      host_write(2'd3, 8'h0D);
      chk("R10 all cleared", {irq_o, wcol_o, bcol_o, start_det_o}, 4'b0000);
      chk("R12 no buffer ok after clear", buf_wr_ok_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_cycles(3);
      test_reset();
      rst_n = 1'b1;
      wait_cycles(3);
      test_busy_reject();
      test_sequence(3, 1'b0);
      test_sequence(10, 1'b1);
      test_locks();
      test_gate();
      test_coll_sda();
      test_coll_scl();
      test_clear();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule